// File: doc/BRIEF.md
# Power-On Reset Delay Sequencer

This block generates the internal reset of a small microcontroller. It combines two conditions. The first is a supply-good level from an analog power-on detector, which arrives already clean. The second is an active-low external reset pin.

Reset stays asserted while either condition is absent. Once both are present, reset is held for a further programmable number of oscillator cycles. When the supply indication goes low, reset returns at once, without waiting for a clock edge. The oscillator clock is treated as always running.

The start-up delay is counted from whichever of the two conditions becomes true last. Tying the pin high therefore gives a delay measured from supply-good. Holding the pin low stretches the start-up until the pin is released. A sticky flag records that a supply-caused reset took place. Software clears it with a one-cycle strobe.

Top module: `por_delay_seq`

## Requirements
- R1: While `supply_ok` is 0, `rst_out` is 1, `tmo_done` is 0 and `por_flag` is 1, whatever the clock, `ext_rst_n` and `clr_flag` do.
- R2: `supply_ok` must already be 1, and `ext_rst_n` is sampled 1 at consecutive rising edges starting with edge 1. Counting edges from 1, `tmo_done` becomes 1 after edge SYNC_STAGES+TIMEOUT and `rst_out` becomes 0 after edge SYNC_STAGES+TIMEOUT+1.
- R3: A falling `supply_ok` drives `rst_out` to 1, `tmo_done` to 0 and `por_flag` to 1 in the same instant, before any further clock edge. The delay count restarts from zero.
- R4: While `ext_rst_n` is held at 0 with the supply good, `rst_out` stays 1 for any length of time. After the pin is released, the R2 timing applies, counted from the first edge at which the pin is sampled 1.
- R5: Suppose `ext_rst_n` is sampled 0 at edge e after start-up has finished. Then `tmo_done` is 0 after edge e+SYNC_STAGES-1, and `rst_out` is 1 after edge e+SYNC_STAGES.
- R6: `rst_out` never falls during the delay count. It changes from 1 to 0 only at an edge where `tmo_done` was 1 just before.
- R7: `por_flag` stays 1 after any supply-caused reset. It ignores pin resets and elapsed time. It clears after a rising edge that samples `clr_flag`=1 with `supply_ok`=1. A strobe while `supply_ok` is 0 has no effect.
- R8: The delay counter saturates at TIMEOUT and never exceeds it. While both conditions hold, `tmo_done` stays 1 and `rst_out` stays 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| supply_ok | input | 1 | Supply above detection level (1); asynchronous clear when 0 |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clr_flag | input | 1 | Write-one strobe that clears `por_flag` |
| rst_out | output | 1 | Internal reset, active high |
| tmo_done | output | 1 | Start-up delay has elapsed and the pin is released |
| por_flag | output | 1 | Sticky record of a supply-caused reset |

## Verification
A stuck or miscounted delay counter shows up as `rst_out` falling one or more edges off the SYNC_STAGES+TIMEOUT+1 mark, which can be seen within about seventy cycles of supply-good. A wrong synchronizer depth shifts both the release edge and the pin-reset reassertion edge by the same amount. An asynchronous path that is missing leaves `rst_out` low for up to a cycle after the supply falls, and a probe taken a nanosecond after the drop exposes it. A flag register that fails to hold or fails to clear is visible on `por_flag` at the next edge after a strobe, or after a pin reset.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    localparam int unsigned POR_TIMEOUT_DEF = 64;
    localparam int unsigned POR_SYNC_DEF    = 2;

    // Bits needed to hold the values 0..limit.
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // Registered control outputs, both forced to 1 by a supply drop.
    typedef struct packed {
        logic rst;
        logic flag;
    } por_ctl_t;

endpackage

// File: rtl/por_pin_sync.sv
module por_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_i,
    output logic pin_o
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = pin_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], pin_i};
        end
    endgenerate

    // Cleared to "pin asserted" while the supply is absent.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign pin_o = sh_q[STAGES-1];

endmodule

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
    parameter int unsigned TIMEOUT = 64,
    parameter int unsigned CW      = 7
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          run,
    output logic          done,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d;
    cnt_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done  = run && (st_q.cnt == LIMIT);
    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/por_delay_seq.sv
module por_delay_seq
    import por_seq_pkg::*;
#(
    parameter int unsigned TIMEOUT     = POR_TIMEOUT_DEF,
    parameter int unsigned SYNC_STAGES = POR_SYNC_DEF
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic ext_rst_n,
    input  logic clr_flag,
    output logic rst_out,
    output logic tmo_done,
    output logic por_flag
);

    localparam int unsigned CW = cnt_bits(TIMEOUT);

    logic          pin_ok;
    logic          done_int;
    logic [CW-1:0] cnt_val;

    por_ctl_t ctl_d;
    por_ctl_t ctl_q;

    por_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk    (clk),
        .arst_n (supply_ok),
        .pin_i  (ext_rst_n),
        .pin_o  (pin_ok)
    );

    por_delay_cnt #(
        .TIMEOUT (TIMEOUT),
        .CW      (CW)
    ) u_delay_cnt (
        .clk    (clk),
        .arst_n (supply_ok),
        .run    (pin_ok),
        .done   (done_int),
        .cnt_o  (cnt_val)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rst  = !done_int;
        ctl_d.flag = ctl_q.flag && !clr_flag;
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            ctl_q.rst  <= 1'b1;
            ctl_q.flag <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Supply loss also forces the outputs directly, with no clock involved.
    assign rst_out  = ctl_q.rst  | ~supply_ok;
    assign por_flag = ctl_q.flag | ~supply_ok;
    assign tmo_done = done_int   &  supply_ok;

endmodule

// File: rtl/por_delay_seq_chk.sv
module por_delay_seq_chk
    import por_seq_pkg::*;
#(
    parameter int unsigned TIMEOUT = POR_TIMEOUT_DEF
) (
    input logic                         clk,
    input logic                         supply_ok,
    input logic                         clr_flag,
    input logic                         rst_out,
    input logic                         tmo_done,
    input logic                         por_flag,
    input logic [cnt_bits(TIMEOUT)-1:0] cnt
);

    localparam int unsigned CW = cnt_bits(TIMEOUT);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    // R1, R3: supply absent forces the outputs without a clock
    always_comb begin
        if (supply_ok === 1'b0) begin
            p_async_hold_r3: assert (rst_out && !tmo_done && por_flag)
                else $error("supply low but outputs not in reset");
        end
    end

    // R2: release follows a completed delay
    p_release_r2: assert property (@(posedge clk) disable iff (!supply_ok)
        tmo_done |=> !rst_out);

    // R2: counter steps by one or restarts
    p_count_step_r2: assert property (@(posedge clk) disable iff (!supply_ok)
        (cnt != '0 && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    // R6: no release without a finished delay
    p_no_glitch_r6: assert property (@(posedge clk) disable iff (!supply_ok)
        !tmo_done |=> rst_out);

    // R7: strobe clears the sticky flag
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!supply_ok)
        clr_flag |=> !por_flag);

    // R7: flag holds without a strobe
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!supply_ok)
        (por_flag && !clr_flag) |=> por_flag);

    // R8: counter saturates
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!supply_ok)
        cnt <= LIMIT);

endmodule

bind por_delay_seq por_delay_seq_chk #(
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk       (clk),
    .supply_ok (supply_ok),
    .clr_flag  (clr_flag),
    .rst_out   (rst_out),
    .tmo_done  (tmo_done),
    .por_flag  (por_flag),
    .cnt       (cnt_val)
);

// File: tb/test_por_delay_seq.sv
`timescale 1ns/1ps
module test_por_delay_seq;

    localparam int unsigned T = 64;
    localparam int unsigned S = 2;

    logic clk = 1'b0;
    logic supply_ok;
    logic ext_rst_n;
    logic clr_flag;
    logic rst_out;
    logic tmo_done;
    logic por_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;
    string phase = "R1";

    // reference state derived from the requirement timing
    logic [S:0] sh_m;
    int  cnt_m;
    bit  done_m, rst_m, flag_m;
    bit  prev_rst, prev_done;

    always #5 clk = ~clk;

    por_delay_seq #(.TIMEOUT(T), .SYNC_STAGES(S)) i_por_delay_seq (
        .clk       (clk),
        .supply_ok (supply_ok),
        .ext_rst_n (ext_rst_n),
        .clr_flag  (clr_flag),
        .rst_out   (rst_out),
        .tmo_done  (tmo_done),
        .por_flag  (por_flag)
    );

    function automatic int next_cnt(input int c, input bit run);
        if (!run) return 0;
        return (c < T) ? c + 1 : T;
    endfunction

    task automatic m_reset();
        sh_m = '0; cnt_m = 0; done_m = 0; rst_m = 1; flag_m = 1;
    endtask

    always @(posedge clk) begin
        if (supply_ok) begin
            cnt_m  = next_cnt(cnt_m, sh_m[S-1]);
            sh_m   = {sh_m[S-1:0], ext_rst_n};
            rst_m  = !done_m;
            done_m = (cnt_m == T) && sh_m[S-1];
            if (clr_flag) flag_m = 0;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(phase, "rst_out", rst_out, supply_ok ? logic'(rst_m) : 1'b1);
        chk(phase, "tmo_done", tmo_done, supply_ok ? logic'(done_m) : 1'b0);
        chk("R7", "por_flag", por_flag, supply_ok ? logic'(flag_m) : 1'b1);
        if (prev_rst && !rst_out) chk("R6", "done before release", logic'(prev_done), 1'b1);
        prev_rst = rst_out; prev_done = tmo_done;
    endtask

    task automatic cyc(input int n, input bit rnd_clr);
        repeat (n) begin
            @(negedge clk);
            compare();
            clr_flag = rnd_clr ? ($urandom % 16 == 0) : 1'b0;
        end
    endtask

    task automatic drop_supply();
        @(negedge clk);
        compare();
        #2 supply_ok = 1'b0;
        m_reset();
        #1;
        chk("R3", "rst_out async", rst_out, 1'b1);
        chk("R3", "tmo_done async", tmo_done, 1'b0);
        chk("R3", "por_flag async", por_flag, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        supply_ok = 1'b1; ext_rst_n = 1'b1; clr_flag = 1'b0;
        prev_rst = 1; prev_done = 0;
        m_reset();
        #1 supply_ok = 1'b0;
        #1;
        chk("R1", "rst_out at start", rst_out, 1'b1);
        chk("R1", "tmo_done at start", tmo_done, 1'b0);
        chk("R1", "por_flag at start", por_flag, 1'b1);
        phase = "R1";
        cyc(6, 1'b1);                                // clr strobes while supply low: R7

        // directed: pin tied high, exact release edge
        phase = "R2";
        supply_ok = 1'b1; clr_flag = 1'b0;
        cyc(T + 12, 1'b0);
        chk("R8", "still released", rst_out, 1'b0);
        phase = "R8";
        cyc(150, 1'b0);

        // directed: flag clear
        @(negedge clk); compare(); clr_flag = 1'b1;
        @(negedge clk); compare(); clr_flag = 1'b0;
        chk("R7", "cleared by strobe", por_flag, 1'b0);

        // directed: pin pulse after start-up
        phase = "R5";
        ext_rst_n = 1'b0;
        cyc(3, 1'b0);
        chk("R5", "pin reasserts reset", rst_out, 1'b1);
        ext_rst_n = 1'b1;
        cyc(T + 6, 1'b0);
        chk("R7", "pin reset leaves flag", por_flag, 1'b0);

        drop_supply();

        // directed: pin held low extends start-up
        phase = "R4";
        ext_rst_n = 1'b0;
        @(negedge clk); compare(); supply_ok = 1'b1;
        cyc(T + 30, 1'b0);
        chk("R4", "held while pin low", rst_out, 1'b1);
        ext_rst_n = 1'b1;
        cyc(T + 8, 1'b0);

        // random trials
        for (int k = 0; k < 40; k++) begin
            drop_supply();
            phase = "R1";
            cyc(1 + $urandom % 5, 1'b1);
            ext_rst_n = ($urandom % 2) ? 1'b1 : 1'b0;
            phase = ext_rst_n ? "R2" : "R4";
            supply_ok = 1'b1;
            if (!ext_rst_n) begin
                cyc($urandom % 20, 1'b1);
                ext_rst_n = 1'b1;
            end
            cyc($urandom % (T + 40), 1'b1);
            if ($urandom % 2) begin
                phase = "R5";
                ext_rst_n = 1'b0;
                cyc(1 + $urandom % 5, 1'b1);
                ext_rst_n = 1'b1;
                cyc(T + 10, 1'b1);
            end
            if ($urandom % 4 == 0) begin
                phase = "R8";
                cyc(200, 1'b1);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule